// File: doc/BRIEF.md
# Pointer-Addressed Host Port

This block is the parallel host side of a chip that holds a configuration register file and a packet buffer. The host sees only eight byte locations, selected by a three-bit address. It reaches every register in the file through an index register and an indirect data location. Each access to the indirect location moves the index on by one. Packet bytes, written by logic inside the chip, stream out through a single read location that pops one byte per access.

The byte-wide data path is split into an input, an output and an output enable, ready for a bidirectional pad. Two static strap inputs choose the strobe scheme. In one scheme, separate read and write strobes are both active low. In the other, a single active-low data strobe is paired with a read/write level. Two active-low chip selects must both be asserted for any access. A ready output goes low briefly while the buffer port fetches its next byte.

Top module: `hp_host_port`

## Requirements
- R1: After reset the index register and every register-file byte are 0, the buffer is empty, the status byte reads 0x01, ready is high and the data output enable is low.
- R2: An access happens only while both chip selects are low and the strap value is 2'b00 (separate strobes) or 2'b01 (single strobe). Strap values 2'b10 and 2'b11 disable the port: writes change nothing and reads do not enable the data output.
- R3: Each assertion of a strobe performs exactly one access, in the first clock cycle it is seen, however long the strobe is held.
- R4: With strap 2'b01, a low data strobe reads when the read/write input is high and writes when it is low. With strap 2'b00, a low read strobe with a high write strobe reads, and a low write strobe with a high read strobe writes.
- R5: Location 0 is the index register. A write keeps the low log2(REG_COUNT) bits of the data byte, and a read returns the index with the upper bits as 0.
- R6: Location 1 reads or writes the register-file byte selected by the index, and the index then advances by one, wrapping from REG_COUNT-1 to 0. Every register-file byte i is presented on the cfg_regs_o bits [8i+7:8i].
- R7: A read of location 2 returns the oldest byte pushed by the internal side and removes it, in push order. A write to location 2 has no effect.
- R8: A read of location 2 with the buffer empty returns 0x00 and sets a sticky underflow flag. The flag is cleared only by writing location 3 with data bit 7 set.
- R9: Location 3 reads as a status byte: bit 0 is buffer empty, bit 1 is buffer full, bit 7 is the underflow flag, and all other bits are 0.
- R10: Locations 4 to 7 read as 0x00, and writes to them change no state.
- R11: Ready is low in exactly the one cycle after a location-2 read starts, and high in every other cycle, including after register accesses.
- R12: The data output enable is high while a valid read strobe is held, and the data output holds the byte read from one cycle after the strobe starts. The enable is low otherwise.
- R13: The buffer holds BUF_DEPTH bytes. buf_full_o is high at that level, and a push while full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_i | input | 2 | Static bus-style strap |
| cs0_n_i | input | 1 | First chip select, active low |
| cs1_n_i | input | 1 | Second chip select, active low |
| strb_a_n_i | input | 1 | Read strobe (separate style) or data strobe (single style), active low |
| strb_b_i | input | 1 | Write strobe, active low (separate style), or read/write level (single style) |
| addr_i | input | 3 | Byte location select |
| data_i | input | 8 | Write data from host |
| data_o | output | 8 | Read data to host |
| data_oe_o | output | 1 | Enable for the data pad driver |
| rdy_o | output | 1 | Ready toward host |
| buf_wr_en_i | input | 1 | Internal push strobe for the packet buffer |
| buf_wr_data_i | input | 8 | Internal push byte |
| buf_full_o | output | 1 | Packet buffer full |
| cfg_regs_o | output | REG_COUNT*8 | Register-file contents, flattened |

## Verification
The bench builds the block with REG_COUNT=16 and BUF_DEPTH=8. With these values it can write and read back every register through the auto-incrementing location and watch the index wrap. It can also fill the buffer to full and attempt one push beyond that. Every buffered byte is drained, with reads alternating between the two strobe schemes, and then one more read underflows. The sweep also covers every spare location, every disabling strap value and each chip select asserted on its own.

// File: rtl/hp_pkg.sv
package hp_pkg;
   localparam int BYTE_W = 8;
   localparam int ADDR_W = 3;

   typedef logic [BYTE_W-1:0] byte_t;

   typedef enum logic [1:0] {
      STYLE_SPLIT  = 2'b00,
      STYLE_SINGLE = 2'b01,
      STYLE_OFF_A  = 2'b10,
      STYLE_OFF_B  = 2'b11
   } bus_style_e;

   localparam logic [ADDR_W-1:0] LOC_INDEX = 3'd0;
   localparam logic [ADDR_W-1:0] LOC_INDIR = 3'd1;
   localparam logic [ADDR_W-1:0] LOC_BUF   = 3'd2;
   localparam logic [ADDR_W-1:0] LOC_STAT  = 3'd3;

   localparam int ST_EMPTY = 0;
   localparam int ST_FULL  = 1;
   localparam int ST_UDF   = 7;
endpackage

// File: rtl/hp_bus_decode.sv
module hp_bus_decode
   import hp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] strap_i,
   input  logic       cs0_n_i,
   input  logic       cs1_n_i,
   input  logic       strb_a_n_i,
   input  logic       strb_b_i,
   output logic       rd_lvl_o,
   output logic       rd_evt_o,
   output logic       wr_evt_o
);
   bus_style_e style;
   logic       chip_sel;
   logic       rd_lvl, wr_lvl;
   logic       rd_q, wr_q;

   assign style    = bus_style_e'(strap_i);
   assign chip_sel = !cs0_n_i && !cs1_n_i;

   always_comb begin
      rd_lvl = 1'b0;
      wr_lvl = 1'b0;
      if (chip_sel) begin
         case (style)
            STYLE_SPLIT: begin
               rd_lvl = !strb_a_n_i && strb_b_i;
               wr_lvl = strb_a_n_i && !strb_b_i;
            end
            STYLE_SINGLE: begin
               rd_lvl = !strb_a_n_i && strb_b_i;
               wr_lvl = !strb_a_n_i && !strb_b_i;
            end
            default: begin
               rd_lvl = 1'b0;
               wr_lvl = 1'b0;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q <= 1'b0;
         wr_q <= 1'b0;
      end else begin
         rd_q <= rd_lvl;
         wr_q <= wr_lvl;
      end
   end

   assign rd_lvl_o = rd_lvl;
   assign rd_evt_o = rd_lvl && !rd_q;
   assign wr_evt_o = wr_lvl && !wr_q;

   // R3: one access per strobe assertion
   p_single_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_evt_o |=> !rd_evt_o);
   p_single_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_evt_o |=> !wr_evt_o);
   // R4: read and write never decoded together
   p_rd_wr_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_lvl && wr_lvl));
endmodule

// File: rtl/hp_index_regs.sv
module hp_index_regs
   import hp_pkg::*;
#(
   parameter int REG_COUNT = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_index_i,
   input  logic                        wr_indir_i,
   input  logic                        rd_indir_i,
   input  byte_t                       wdata_i,
   output byte_t                       index_byte_o,
   output byte_t                       indir_byte_o,
   output logic [REG_COUNT*BYTE_W-1:0] regs_flat_o
);
   localparam int IDX_W = $clog2(REG_COUNT);

   if (REG_COUNT < 2 || REG_COUNT > 256 || (REG_COUNT & (REG_COUNT - 1)) != 0) begin : g_bad_count
      $error("REG_COUNT must be a power of two from 2 to 256");
   end

   logic [IDX_W-1:0] idx_q;
   byte_t            regs_q [REG_COUNT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (wr_index_i) begin
         idx_q <= wdata_i[IDX_W-1:0];
      end else if (wr_indir_i || rd_indir_i) begin
         idx_q <= idx_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < REG_COUNT; i++) regs_q[i] <= '0;
      end else if (wr_indir_i) begin
         regs_q[idx_q] <= wdata_i;
      end
   end

   assign indir_byte_o = regs_q[idx_q];

   if (IDX_W < BYTE_W) begin : g_pad
      assign index_byte_o = {{(BYTE_W-IDX_W){1'b0}}, idx_q};
   end else begin : g_full
      assign index_byte_o = idx_q;
   end

   for (genvar g = 0; g < REG_COUNT; g++) begin : g_flat
      assign regs_flat_o[g*BYTE_W +: BYTE_W] = regs_q[g];
   end

   // R6: index advances by one per indirect access
   p_index_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_indir_i || rd_indir_i) && !wr_index_i |=> idx_q == IDX_W'($past(idx_q) + 1'b1));
   // R6: register file only changes on an indirect write
   p_regs_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_indir_i |=> $stable(regs_flat_o));
endmodule

// File: rtl/hp_pkt_fifo.sv
module hp_pkt_fifo
   import hp_pkg::*;
#(
   parameter int DEPTH = 8
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  push_i,
   input  byte_t push_data_i,
   input  logic  pop_i,
   output byte_t head_o,
   output logic  empty_o,
   output logic  full_o
);
   localparam int AW = $clog2(DEPTH);
   localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

   if (DEPTH < 2 || DEPTH > 1024 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two from 2 to 1024");
   end

   byte_t         mem_q [DEPTH];
   logic [AW:0]   wptr_q, rptr_q;
   logic [AW:0]   level;
   logic          push_ok, pop_ok;

   assign level   = wptr_q - rptr_q;
   assign empty_o = (level == '0);
   assign full_o  = (level == FULL_CNT);
   assign push_ok = push_i && !full_o;
   assign pop_ok  = pop_i && !empty_o;
   assign head_o  = mem_q[rptr_q[AW-1:0]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q <= '0;
         rptr_q <= '0;
      end else begin
         if (push_ok) wptr_q <= wptr_q + 1'b1;
         if (pop_ok)  rptr_q <= rptr_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok) mem_q[wptr_q[AW-1:0]] <= push_data_i;
   end

   // R13: push while full is dropped
   p_no_overflow_r13: assert property (@(posedge clk) disable iff (!rst_n)
      full_o && push_i && !pop_i |=> full_o && wptr_q == $past(wptr_q));
   // R7: a pop of a non-empty buffer advances the read side once
   p_pop_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i && !empty_o |=> rptr_q == (AW+1)'($past(rptr_q) + 1'b1));
   // R8: popping an empty buffer moves nothing
   p_empty_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i && empty_o |=> $stable(rptr_q));
endmodule

// File: rtl/hp_host_port.sv
module hp_host_port
   import hp_pkg::*;
#(
   parameter int REG_COUNT = 16,
   parameter int BUF_DEPTH = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [1:0]                  strap_i,
   input  logic                        cs0_n_i,
   input  logic                        cs1_n_i,
   input  logic                        strb_a_n_i,
   input  logic                        strb_b_i,
   input  logic [2:0]                  addr_i,
   input  logic [7:0]                  data_i,
   output logic [7:0]                  data_o,
   output logic                        data_oe_o,
   output logic                        rdy_o,
   input  logic                        buf_wr_en_i,
   input  logic [7:0]                  buf_wr_data_i,
   output logic                        buf_full_o,
   output logic [REG_COUNT*8-1:0]      cfg_regs_o
);
   logic  rd_lvl, rd_evt, wr_evt;
   logic  at_index, at_indir, at_buf, at_stat;
   byte_t index_byte, indir_byte, head_byte;
   byte_t stat_byte, rd_mux, rd_data_q;
   logic  buf_empty, buf_full;
   logic  udf_q, rdy_q;
   logic  udf_clr;

   hp_bus_decode u_decode (
      .clk        (clk),
      .rst_n      (rst_n),
      .strap_i    (strap_i),
      .cs0_n_i    (cs0_n_i),
      .cs1_n_i    (cs1_n_i),
      .strb_a_n_i (strb_a_n_i),
      .strb_b_i   (strb_b_i),
      .rd_lvl_o   (rd_lvl),
      .rd_evt_o   (rd_evt),
      .wr_evt_o   (wr_evt)
   );

   assign at_index = (addr_i == LOC_INDEX);
   assign at_indir = (addr_i == LOC_INDIR);
   assign at_buf   = (addr_i == LOC_BUF);
   assign at_stat  = (addr_i == LOC_STAT);

   hp_index_regs #(.REG_COUNT(REG_COUNT)) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_index_i   (wr_evt && at_index),
      .wr_indir_i   (wr_evt && at_indir),
      .rd_indir_i   (rd_evt && at_indir),
      .wdata_i      (data_i),
      .index_byte_o (index_byte),
      .indir_byte_o (indir_byte),
      .regs_flat_o  (cfg_regs_o)
   );

   hp_pkt_fifo #(.DEPTH(BUF_DEPTH)) u_fifo (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (buf_wr_en_i),
      .push_data_i (buf_wr_data_i),
      .pop_i       (rd_evt && at_buf),
      .head_o      (head_byte),
      .empty_o     (buf_empty),
      .full_o      (buf_full)
   );

   assign buf_full_o = buf_full;
   assign udf_clr    = wr_evt && at_stat && data_i[ST_UDF];

   always_comb begin
      stat_byte           = '0;
      stat_byte[ST_EMPTY] = buf_empty;
      stat_byte[ST_FULL]  = buf_full;
      stat_byte[ST_UDF]   = udf_q;
   end

   always_comb begin
      rd_mux = '0;
      if (at_index)      rd_mux = index_byte;
      else if (at_indir) rd_mux = indir_byte;
      else if (at_buf)   rd_mux = buf_empty ? '0 : head_byte;
      else if (at_stat)  rd_mux = stat_byte;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data_q <= '0;
         udf_q     <= 1'b0;
         rdy_q     <= 1'b1;
      end else begin
         if (rd_evt) rd_data_q <= rd_mux;
         if (rd_evt && at_buf && buf_empty) udf_q <= 1'b1;
         else if (udf_clr)                  udf_q <= 1'b0;
         rdy_q <= !(rd_evt && at_buf);
      end
   end

   assign data_o    = rd_lvl ? rd_data_q : '0;
   assign data_oe_o = rd_lvl;
   assign rdy_o     = rdy_q;

   // R11: ready is never low two cycles running
   p_rdy_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !rdy_o |=> rdy_o);
   // R8: underflow flag holds until an explicit clear
   p_udf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      udf_q && !udf_clr |=> udf_q);
   // R8: empty buffer read yields zero data
   p_udf_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_evt && at_buf && buf_empty |=> data_o == 8'h00);
   // R2: no output drive when the strap disables the port
   p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      strap_i[1] |-> !data_oe_o);
endmodule

// File: tb/hp_host_port_tb_top.sv
module hp_host_port_tb_top;
   localparam int NREG  = 16;
   localparam int DEPTH = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] strap = 2'b00;
   logic cs0_n = 1'b1, cs1_n = 1'b1;
   logic sa_n = 1'b1, sb = 1'b1;
   logic [2:0] addr = '0;
   logic [7:0] din = '0;
   logic [7:0] dout;
   logic oe, rdy, wr_en = 1'b0, full;
   logic [7:0] wr_data = '0;
   logic [NREG*8-1:0] cfg;
   logic cs0_act = 1'b0, cs1_act = 1'b0;
   int total = 0, bad = 0;
   logic [7:0] d;
   logic r1, r2, e1;

   always #10 clk = ~clk;

   hp_host_port #(.REG_COUNT(NREG), .BUF_DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n), .strap_i(strap), .cs0_n_i(cs0_n), .cs1_n_i(cs1_n),
      .strb_a_n_i(sa_n), .strb_b_i(sb), .addr_i(addr), .data_i(din), .data_o(dout),
      .data_oe_o(oe), .rdy_o(rdy), .buf_wr_en_i(wr_en), .buf_wr_data_i(wr_data),
      .buf_full_o(full), .cfg_regs_o(cfg)
   );

   function automatic logic [7:0] fval(int i); return 8'((i * 29 + 7) & 255); endfunction
   function automatic logic [7:0] gval(int i); return 8'((i * 53 + 17) & 255); endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic set_strobe(input bit is_rd);
      if (strap == 2'b01) begin
         sa_n = 1'b0; sb = is_rd;
      end else begin
         sa_n = is_rd ? 1'b0 : 1'b1;
         sb   = is_rd ? 1'b1 : 1'b0;
      end
   endtask

   task automatic go_idle();
      cs0_n = 1'b1; cs1_n = 1'b1; sa_n = 1'b1; sb = 1'b1;
   endtask

   task automatic host_wr(input logic [2:0] a, input logic [7:0] v, input int hold);
      @(negedge clk);
      addr = a; din = v; cs0_n = cs0_act; cs1_n = cs1_act; set_strobe(1'b0);
      repeat (1 + hold) @(negedge clk);
      go_idle();
   endtask

   task automatic host_rd(input logic [2:0] a, input int hold,
                          output logic [7:0] v, output logic rdy1, output logic rdy2,
                          output logic oe1);
      @(negedge clk);
      addr = a; cs0_n = cs0_act; cs1_n = cs1_act; set_strobe(1'b1);
      @(negedge clk);
      v = dout; rdy1 = rdy; oe1 = oe;
      @(negedge clk);
      rdy2 = rdy;
      repeat (hold) @(negedge clk);
      go_idle();
   endtask

   task automatic push(input logic [7:0] v);
      @(negedge clk);
      wr_en = 1'b1; wr_data = v;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 rdy", rdy, 1);
      chk("R1 oe", oe, 0);
      chk("R1 full", full, 0);
      chk("R1 regs", (cfg == '0), 1);
      host_rd(3'd3, 0, d, r1, r2, e1); chk("R1 R9 status", d, 8'h01);
      host_rd(3'd0, 0, d, r1, r2, e1); chk("R1 index", d, 0);

      // separate strobes: fill all registers
      strap = 2'b00;
      host_wr(3'd0, 8'h00, 0);
      for (int i = 0; i < NREG; i++) host_wr(3'd1, fval(i), 0);
      for (int i = 0; i < NREG; i++) chk("R6 reg contents", cfg[i*8 +: 8], fval(i));
      host_rd(3'd0, 0, d, r1, r2, e1); chk("R6 index wrap", d, 0);
      host_wr(3'd0, 8'hF3, 0);
      host_rd(3'd0, 0, d, r1, r2, e1); chk("R5 index low bits", d, 3);
      host_rd(3'd1, 0, d, r1, r2, e1); chk("R6 indirect read", d, fval(3));
      chk("R11 rdy on reg read", {r1, r2}, 2'b11);
      host_rd(3'd0, 0, d, r1, r2, e1); chk("R6 index after read", d, 4);

      // single strobe with read/write level
      strap = 2'b01;
      host_wr(3'd0, 8'h00, 0);
      for (int i = 0; i < NREG; i++) begin
         host_rd(3'd1, i % 3, d, r1, r2, e1);
         chk("R4 single-strobe read", d, fval(i));
      end
      host_rd(3'd0, 0, d, r1, r2, e1); chk("R3 one step per strobe", d, 0);
      host_wr(3'd0, 8'h05, 0);
      host_wr(3'd1, 8'hA5, 2);
      chk("R4 single-strobe write", cfg[5*8 +: 8], 8'hA5);
      host_rd(3'd0, 0, d, r1, r2, e1); chk("R3 held write steps once", d, 6);

      // packet buffer
      host_rd(3'd3, 0, d, r1, r2, e1); chk("R9 empty status", d, 8'h01);
      for (int i = 0; i < DEPTH; i++) push(gval(i));
      push(8'hEE);
      @(negedge clk);
      chk("R13 full flag", full, 1);
      host_rd(3'd3, 0, d, r1, r2, e1); chk("R9 full status", d, 8'h02);
      for (int i = 0; i < DEPTH; i++) begin
         strap = (i % 2 == 1) ? 2'b01 : 2'b00;
         host_rd(3'd2, 0, d, r1, r2, e1);
         chk("R7 buffer order", d, gval(i));
         chk("R11 rdy low one cycle", {r1, r2}, 2'b01);
         chk("R12 oe during read", e1, 1);
         @(negedge clk);
         chk("R12 oe after read", oe, 0);
      end
      strap = 2'b00;
      host_rd(3'd2, 0, d, r1, r2, e1); chk("R8 empty read data", d, 8'h00);
      chk("R11 rdy on empty read", {r1, r2}, 2'b01);
      host_rd(3'd3, 0, d, r1, r2, e1); chk("R8 underflow set", d, 8'h81);
      host_wr(3'd3, 8'h7F, 0);
      host_rd(3'd3, 0, d, r1, r2, e1); chk("R8 flag kept without bit7", d, 8'h81);
      host_wr(3'd3, 8'h80, 0);
      host_rd(3'd3, 0, d, r1, r2, e1); chk("R8 flag cleared", d, 8'h01);
      host_wr(3'd2, 8'h55, 0);
      host_rd(3'd3, 0, d, r1, r2, e1); chk("R7 write to buffer ignored", d, 8'h01);

      // spare locations
      for (int a = 4; a < 8; a++) begin
         host_wr(3'(a), 8'hFF, 0);
         host_rd(3'(a), 0, d, r1, r2, e1);
         chk("R10 spare reads zero", d, 0);
         chk("R11 rdy on spare read", {r1, r2}, 2'b11);
      end
      host_rd(3'd0, 0, d, r1, r2, e1); chk("R10 index untouched", d, 6);
      chk("R10 reg5 untouched", cfg[5*8 +: 8], 8'hA5);

      // disabling straps and partial chip select
      for (int s = 2; s < 4; s++) begin
         strap = 2'(s);
         host_wr(3'd0, 8'h09, 0);
         host_rd(3'd0, 0, d, r1, r2, e1);
         chk("R2 strap off no drive", e1, 0);
      end
      strap = 2'b00;
      cs0_act = 1'b1; host_wr(3'd0, 8'h09, 0);
      cs0_act = 1'b0; cs1_act = 1'b1; host_wr(3'd0, 8'h09, 0);
      host_rd(3'd0, 0, d, r1, r2, e1);
      chk("R2 single cs no read drive", e1, 0);
      cs1_act = 1'b0;
      host_rd(3'd0, 0, d, r1, r2, e1); chk("R2 index unchanged", d, 6);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule